// File: doc/BRIEF.md
# Supply Monitor Sequencing Controller

This block turns three supply comparator flags into a sequence of control actions. The flags are already digital and come from analog circuits outside the block. They are nested: below-warning, below-minimum and below-backup. Each deeper threshold adds an action on top of the ones before it:

- A drop past the warning level raises a maskable interrupt request carrying a fixed vector. Normal operation continues.
- A drop past the minimum level holds the system in reset, pulls the shared reset-status line low, and parks every memory and peripheral enable and the write strobe at their inactive high level.
- A drop past the backup level also clears the backup indicator.

The reset-status line is modelled as open drain. The block drives it through a pull-low request and reads it back through a sense input. Another device that pulls the line low therefore also puts this block into reset, so several devices enter power-down reset together. When the last cause of reset has gone away, the block keeps reset asserted for a fixed number of clocks before releasing the system. It does the same after its own reset.

Top module: `supply_seq_ctrl`

## Requirements
- R1: The interrupt vector output always reads `WARN_VECTOR` (default 8'h2B). On each entry into the warning state, `irq_req` is high for exactly one clock cycle. It is visible after the second rising edge following the flag change, and stays low while the warning condition persists.
- R2: While `warn_irq_en` is 0, entering the warning state produces no pulse on `irq_req`.
- R3: Two rising edges after `flag_min` goes high, `sys_reset` is 1 and `rst_pin_low` is 1. `rst_pin_low` returns to 0 two edges after the flag clears.
- R4: While `sys_reset` is 1, every bit of `en_n_out` and `rw_n_out` is 1. While `sys_reset` is 0, these outputs equal `en_n_in` and `rw_n_in`.
- R5: A low level on `rst_pin_in` forces `sys_reset` to 1 two edges later. It does not set `rst_pin_low`.
- R6: `sys_reset` falls exactly `POR_CYCLES` rising edges after the synchronized reset causes are last seen inactive. With an external wired-AND line, a supply-driven reset therefore releases `POR_CYCLES`+4 edges after `flag_min` clears. An external pull releases `POR_CYCLES`+2 edges after it is removed.
- R7: Two edges after `flag_bkp` goes high, `bkp_n` is 0. The backup flag alone also implies the minimum and warning states: it causes reset, the pull-low request and a warning pulse.
- R8: After `rst_n` is released, `sys_reset` stays 1 for exactly `POR_CYCLES` rising edges.
- R9: A warning flag alone does not assert `sys_reset`, `rst_pin_low`, or the forcing of the enables.
- R10: Every flag and the sense input pass through two flip-flops. No output responds after only one rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| flag_warn | input | 1 | Supply below warning threshold |
| flag_min | input | 1 | Supply below minimum operating threshold |
| flag_bkp | input | 1 | Supply below backup-switch threshold |
| warn_irq_en | input | 1 | Enables the warning interrupt |
| rst_pin_in | input | 1 | Sensed level of the shared reset-status line |
| en_n_in | input | NUM_EN | Active-low decoded enables from the core |
| rw_n_in | input | 1 | Active-low write strobe from the core |
| rst_pin_low | output | 1 | Request to pull the reset-status line low |
| sys_reset | output | 1 | System reset, active high |
| en_n_out | output | NUM_EN | Gated active-low enables |
| rw_n_out | output | 1 | Gated write strobe |
| irq_req | output | 1 | One-cycle warning interrupt request |
| irq_vector | output | VEC_W | Warning interrupt vector address |
| bkp_n | output | 1 | Low while on backup supply |

## Verification
The bench builds the block with `POR_CYCLES` set to 20 and `NUM_EN` set to 3. At that size the exact release cycle can be checked one edge on either side after a power-on, a supply dip, an external pull and a backup drop, all within a short run. Bench and block meet in a wired-AND model of the reset line. That model makes visible the two extra edges that the block's own pull-low adds to the release delay. Flag combinations that break the nesting, such as the minimum or backup flag without the warning flag, are driven on purpose to show that severity escalates.

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl #(
  parameter int NUM_EN = 4,
  parameter int POR_CYCLES = 21504,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] WARN_VECTOR = 8'h2B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_warn,
  input  logic              flag_min,
  input  logic              flag_bkp,
  input  logic              warn_irq_en,
  input  logic              rst_pin_in,
  input  logic [NUM_EN-1:0] en_n_in,
  input  logic              rw_n_in,
  output logic              rst_pin_low,
  output logic              sys_reset,
  output logic [NUM_EN-1:0] en_n_out,
  output logic              rw_n_out,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              bkp_n
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [3:0] SYNC_INIT = 4'b1000;

  logic [3:0]    raw, sync1, sync2;
  logic          lvl_warn, lvl_min, lvl_bkp, ext_low, hold, warn_q;
  logic [CW-1:0] cnt;

  assign raw      = {rst_pin_in, flag_bkp, flag_min, flag_warn};
  assign lvl_bkp  = sync2[2];
  assign lvl_min  = sync2[1] | lvl_bkp;
  assign lvl_warn = sync2[0] | lvl_min;
  assign ext_low  = ~sync2[3];
  assign hold     = lvl_min | ext_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= SYNC_INIT;
      sync2  <= SYNC_INIT;
      warn_q <= 1'b0;
      cnt    <= CW'(POR_CYCLES);
    end else begin
      sync1  <= raw;
      sync2  <= sync1;
      warn_q <= lvl_warn;
      if (hold)
        cnt <= CW'(POR_CYCLES);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign sys_reset   = hold | (cnt != '0);
  assign rst_pin_low = lvl_min;
  assign en_n_out    = sys_reset ? {NUM_EN{1'b1}} : en_n_in;
  assign rw_n_out    = sys_reset | rw_n_in;
  assign irq_req     = warn_irq_en & lvl_warn & ~warn_q;
  assign irq_vector  = WARN_VECTOR;
  assign bkp_n       = ~lvl_bkp;
endmodule

module supply_seq_chk #(
  parameter int NUM_EN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_reset,
  input logic              rst_pin_low,
  input logic              irq_req,
  input logic              warn_irq_en,
  input logic              bkp_n,
  input logic [NUM_EN-1:0] en_n_out,
  input logic              rw_n_out
);
  // R1
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  // R2
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> warn_irq_en);
  // R3
  pull_implies_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_low |-> sys_reset);
  // R4
  enables_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> (&en_n_out && rw_n_out));
  // R6
  release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_reset) |-> !rst_pin_low);
  // R7
  backup_escalates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bkp_n |-> (rst_pin_low && sys_reset));
endmodule

bind supply_seq_ctrl supply_seq_chk #(.NUM_EN(NUM_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .rst_pin_low(rst_pin_low),
  .irq_req(irq_req), .warn_irq_en(warn_irq_en), .bkp_n(bkp_n),
  .en_n_out(en_n_out), .rw_n_out(rw_n_out)
);

// File: tb/sim_supply_seq_ctrl.sv
module sim_supply_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 3;
  localparam int POR = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flag_warn = 0, flag_min = 0, flag_bkp = 0, warn_irq_en = 1, ext_pull = 0;
  logic [NE-1:0] en_n_in = 3'b010;
  logic rw_n_in = 1'b0;
  logic rst_pin_low, sys_reset, rw_n_out, irq_req, bkp_n, rst_pin_in;
  logic [NE-1:0] en_n_out;
  logic [7:0] irq_vector;
  int checks = 0, failures = 0;
  bit finished = 0;

  assign rst_pin_in = ~(ext_pull | rst_pin_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_seq_ctrl #(.NUM_EN(NE), .POR_CYCLES(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .flag_warn(flag_warn), .flag_min(flag_min),
    .flag_bkp(flag_bkp), .warn_irq_en(warn_irq_en), .rst_pin_in(rst_pin_in),
    .en_n_in(en_n_in), .rw_n_in(rw_n_in), .rst_pin_low(rst_pin_low),
    .sys_reset(sys_reset), .en_n_out(en_n_out), .rw_n_out(rw_n_out),
    .irq_req(irq_req), .irq_vector(irq_vector), .bkp_n(bkp_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_power_on;
    @(negedge clk);
    chk("R8 reset during rst_n", sys_reset, 1);
    chk("R1 vector value", irq_vector, 8'h2B);
    chk("R7 bkp_n idle", bkp_n, 1);
    rst_n = 1'b1;
    step(POR - 1);
    chk("R8 still held one edge early", sys_reset, 1);
    step(1);
    chk("R8 released at POR", sys_reset, 0);
    chk("R4 enables pass", en_n_out, 3'b010);
    chk("R4 strobe pass", rw_n_out, 0);
  endtask

  task automatic t_warning;
    warn_irq_en = 1; flag_warn = 1;
    step(1);
    chk("R10 no irq after one edge", irq_req, 0);
    step(1);
    chk("R1 irq pulse", irq_req, 1);
    chk("R1 vector during pulse", irq_vector, 8'h2B);
    chk("R9 warning leaves reset low", sys_reset, 0);
    chk("R9 warning no pull", rst_pin_low, 0);
    chk("R9 enables still pass", en_n_out, 3'b010);
    step(1);
    chk("R1 pulse ends", irq_req, 0);
    step(3);
    chk("R1 no repeat while held", irq_req, 0);
    flag_warn = 0;
    step(3);
  endtask

  task automatic t_masked;
    int seen = 0;
    warn_irq_en = 0; flag_warn = 1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (irq_req) seen++;
    end
    chk("R2 masked warning", seen, 0);
    flag_warn = 0; step(3); warn_irq_en = 1;
  endtask

  task automatic t_min_dip;
    flag_warn = 1; flag_min = 1;
    step(1);
    chk("R10 no reset after one edge", sys_reset, 0);
    step(1);
    chk("R3 reset asserted", sys_reset, 1);
    chk("R3 pull asserted", rst_pin_low, 1);
    chk("R4 enables parked", en_n_out, 3'b111);
    chk("R4 strobe parked", rw_n_out, 1);
    step(4);
    flag_warn = 0; flag_min = 0;
    step(2);
    chk("R3 pull released", rst_pin_low, 0);
    step(POR + 1);
    chk("R6 held one edge before release", sys_reset, 1);
    step(1);
    chk("R6 released", sys_reset, 0);
    chk("R4 enables restored", en_n_out, 3'b010);
  endtask

  task automatic t_min_only;
    flag_min = 1;
    step(2);
    chk("R1 warning implied by min flag", irq_req, 1);
    chk("R3 reset from min flag alone", sys_reset, 1);
    flag_min = 0;
    step(POR + 6);
    chk("R6 recovered", sys_reset, 0);
  endtask

  task automatic t_ext_pull;
    ext_pull = 1;
    step(2);
    chk("R5 external reset", sys_reset, 1);
    chk("R5 no self pull", rst_pin_low, 0);
    chk("R4 enables parked on ext", en_n_out, 3'b111);
    step(3);
    ext_pull = 0;
    step(POR + 1);
    chk("R6 ext held one edge before release", sys_reset, 1);
    step(1);
    chk("R6 ext released", sys_reset, 0);
  endtask

  task automatic t_backup;
    flag_bkp = 1;
    step(1);
    chk("R10 bkp_n after one edge", bkp_n, 1);
    step(1);
    chk("R7 bkp_n low", bkp_n, 0);
    chk("R7 reset from backup", sys_reset, 1);
    chk("R7 pull from backup", rst_pin_low, 1);
    chk("R7 warning pulse from backup", irq_req, 1);
    flag_bkp = 0;
    step(2);
    chk("R7 bkp_n restored", bkp_n, 1);
    step(POR + 6);
    chk("R6 recovered after backup", sys_reset, 0);
  endtask

  task automatic t_passthrough;
    en_n_in = 3'b101; rw_n_in = 1'b1;
    step(1);
    chk("R4 new enables pass", en_n_out, 3'b101);
    chk("R4 strobe high passes", rw_n_out, 1);
  endtask

  initial begin
    t_power_on();
    t_warning();
    t_masked();
    t_min_dip();
    t_min_only();
    t_ext_pull();
    t_backup();
    t_passthrough();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule